// File: doc/BRIEF.md
# Packed Byte and Lane Permutation Unit

This unit rearranges bytes, 32-bit lanes and bits of packed operands in one of a fixed set of patterns. It sits beside a datapath that has already decoded an operation. Each strobe carries a 4-bit operation code with two 32-bit words, or two 64-bit words for the lane operations. Exactly one clock later the unit presents a 64-bit result with a valid flag. Between strobes the last result is held.

For the byte operations, the 32-bit word `src_a` supplies bytes 7..4 of a virtual 8-byte string and `src_b` supplies bytes 3..0. For the lane operations, `wide_a` supplies 32-bit lanes 3..2 and `wide_b` supplies lanes 1..0. The unit also has two bit-level functions on `src_a`: one reverses the bits inside each byte, and one counts how many bits below the sign bit repeat it. Every result built from 32-bit operations sits in the low word of the result, with the high word cleared.

The operation codes are: 0 byte roll left, 1 byte roll right, 2 byte interleave high, 3 byte interleave low, 4 byte sort, 5 byte swap, 6 lane roll, 7 lane split high, 8 lane split low, 9 per-byte bit reversal, 10 sign-run count. Codes 11 to 15 are unused.

Top module: `lane_perm_unit`

## Requirements
- R1: Code 0 returns bytes 6,5,4,3 of {src_a,src_b}, listed from most to least significant. Code 1 returns bytes 4,3,2,1, in the same order.
- R2: Code 2 returns bytes 7,3,6,2, most significant first. Code 3 returns bytes 5,1,4,0.
- R3: Code 4 maps src_a bytes 3,2,1,0 to 3,1,2,0. Code 5 maps them to 2,3,0,1. In both codes the value of src_b has no effect on the result.
- R4: Code 6 returns lanes 2,1 of {wide_a,wide_b}, with lane 2 in the upper word.
- R5: Code 7 returns lanes 3,1 and code 8 returns lanes 2,0, with the higher lane in the upper word in each case.
- R6: Code 9 reverses the 8 bits inside each byte of src_a and does not move any byte.
- R7: Code 10 counts the consecutive bits of src_a, starting at bit 30 and going down, that equal bit 31. The sign bit itself is not counted. An input of 0 or all-ones gives 31. An input whose bit 30 differs from bit 31 gives 0.
- R8: Codes 11 to 15 give an all-zero result and still assert out_valid.
- R9: out_valid is high in exactly the cycle after a cycle with in_strobe high. The result is loaded only on a strobe and otherwise holds its value.
- R10: A synchronous reset clears out_valid and out_result. When reset and a strobe fall in the same cycle, the reset wins.
- R11: For codes 0 to 5, 9 and 10, bits 63..32 of out_result are zero, whatever the value of wide_a and wide_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_strobe | input | 1 | Operation request for this cycle |
| opcode | input | 4 | Operation code |
| src_a | input | 32 | First word operand: bytes 7..4, or the single word |
| src_b | input | 32 | Second word operand: bytes 3..0 |
| wide_a | input | 64 | First lane operand: lanes 3..2 |
| wide_b | input | 64 | Second lane operand: lanes 1..0 |
| out_valid | output | 1 | Result valid, one clock after the strobe |
| out_result | output | 64 | Registered result |

## Verification
Two things can land on the output register in the same cycle. The first is a reset that coincides with a strobe. The bench raises both together and expects a cleared result with valid low. The second is a new capture made while the previous result is still being presented. The bench issues strobes on consecutive cycles with different codes and checks that each result appears once, in its own cycle, and is not mixed with its neighbour. The wide operands are kept non-zero throughout, so that any leak into the high word of a 32-bit operation shows up.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_BROLL_L   = 4'd0,
        OP_BROLL_R   = 4'd1,
        OP_BMIX_HI   = 4'd2,
        OP_BMIX_LO   = 4'd3,
        OP_BSORT     = 4'd4,
        OP_BSWAP     = 4'd5,
        OP_LROLL     = 4'd6,
        OP_LSPLIT_HI = 4'd7,
        OP_LSPLIT_LO = 4'd8,
        OP_BITREV    = 4'd9,
        OP_SIGNRUN   = 4'd10
    } perm_op_e;

    localparam logic [OP_W-1:0] OP_LAST_USED = 4'd10;

endpackage

// File: rtl/byte_shuffle_core.sv
module byte_shuffle_core
    import lane_perm_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int BW = BYTE_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    hi_word,
    input  logic [W-1:0]    lo_word,
    output logic [W-1:0]    res
);
    // byte k of the 8-byte string {hi_word, lo_word}
    logic [2*W-1:0] cat;
    assign cat = {hi_word, lo_word};

    always_comb begin
        unique case (op)
            OP_BROLL_L: res = {cat[6*BW +: BW], cat[5*BW +: BW], cat[4*BW +: BW], cat[3*BW +: BW]};
            OP_BROLL_R: res = {cat[4*BW +: BW], cat[3*BW +: BW], cat[2*BW +: BW], cat[1*BW +: BW]};
            OP_BMIX_HI: res = {cat[7*BW +: BW], cat[3*BW +: BW], cat[6*BW +: BW], cat[2*BW +: BW]};
            OP_BMIX_LO: res = {cat[5*BW +: BW], cat[1*BW +: BW], cat[4*BW +: BW], cat[0*BW +: BW]};
            OP_BSORT:   res = {hi_word[3*BW +: BW], hi_word[1*BW +: BW], hi_word[2*BW +: BW], hi_word[0*BW +: BW]};
            OP_BSWAP:   res = {hi_word[2*BW +: BW], hi_word[3*BW +: BW], hi_word[0*BW +: BW], hi_word[1*BW +: BW]};
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/word_lane_core.sv
module word_lane_core
    import lane_perm_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [2*W-1:0]  pair_hi,
    input  logic [2*W-1:0]  pair_lo,
    output logic [2*W-1:0]  res
);
    localparam int LANES = 4;
    logic [W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES / 2; g++) begin : g_split
        assign lane[g]             = pair_lo[g*W +: W];
        assign lane[g + LANES / 2] = pair_hi[g*W +: W];
    end

    always_comb begin
        unique case (op)
            OP_LROLL:     res = {lane[2], lane[1]};
            OP_LSPLIT_HI: res = {lane[3], lane[1]};
            OP_LSPLIT_LO: res = {lane[2], lane[0]};
            default:      res = '0;
        endcase
    end
endmodule

// File: rtl/bit_scan_core.sv
module bit_scan_core
    import lane_perm_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int BW = BYTE_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    word,
    output logic [W-1:0]    res
);
    localparam int NBYTES = W / BW;
    localparam int CNT_W  = $clog2(W);

    logic [W-1:0]     flipped;
    logic [CNT_W-1:0] run_len;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < BW; i++) begin : g_bit
            assign flipped[b*BW + i] = word[b*BW + BW - 1 - i];
        end
    end

    always_comb begin
        logic alive;
        alive   = 1'b1;
        run_len = '0;
        for (int i = W - 2; i >= 0; i--) begin
            alive   = alive & (word[i] ~^ word[W-1]);
            run_len = run_len + {{(CNT_W-1){1'b0}}, alive};
        end
    end

    always_comb begin
        unique case (op)
            OP_BITREV:  res = flipped;
            OP_SIGNRUN: res = {{(W-CNT_W){1'b0}}, run_len};
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/lane_perm_unit.sv
module lane_perm_unit
    import lane_perm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_strobe,
    input  logic [OP_W-1:0]     opcode,
    input  logic [WORD_W-1:0]   src_a,
    input  logic [WORD_W-1:0]   src_b,
    input  logic [2*WORD_W-1:0] wide_a,
    input  logic [2*WORD_W-1:0] wide_b,
    output logic                out_valid,
    output logic [2*WORD_W-1:0] out_result
);
    localparam int RES_W = 2 * WORD_W;

    logic [WORD_W-1:0] byte_res;
    logic [WORD_W-1:0] bit_res;
    logic [RES_W-1:0]  lane_res;
    logic [RES_W-1:0]  next_res;

    byte_shuffle_core u_bytes (
        .op      (opcode),
        .hi_word (src_a),
        .lo_word (src_b),
        .res     (byte_res)
    );

    word_lane_core u_lanes (
        .op      (opcode),
        .pair_hi (wide_a),
        .pair_lo (wide_b),
        .res     (lane_res)
    );

    bit_scan_core u_bits (
        .op   (opcode),
        .word (src_a),
        .res  (bit_res)
    );

    always_comb begin
        unique case (opcode)
            OP_BROLL_L, OP_BROLL_R, OP_BMIX_HI,
            OP_BMIX_LO, OP_BSORT, OP_BSWAP:       next_res = {{WORD_W{1'b0}}, byte_res};
            OP_LROLL, OP_LSPLIT_HI, OP_LSPLIT_LO: next_res = lane_res;
            OP_BITREV, OP_SIGNRUN:                next_res = {{WORD_W{1'b0}}, bit_res};
            default:                              next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_strobe;
            if (in_strobe) begin
                out_result <= next_res;
            end
        end
    end
endmodule

// File: rtl/lane_perm_unit_chk.sv
module lane_perm_unit_chk
    import lane_perm_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_strobe,
    input logic [OP_W-1:0]     opcode,
    input logic [WORD_W-1:0]   src_a,
    input logic                out_valid,
    input logic [2*WORD_W-1:0] out_result
);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_strobe |=> out_valid);

    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_strobe |=> !out_valid);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_strobe |=> $stable(out_result));

    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (in_strobe && opcode > OP_LAST_USED) |=> (out_result == '0));

    assert_signrun_range_R7: assert property (@(posedge clk) disable iff (rst)
        (in_strobe && opcode == OP_SIGNRUN) |=> (out_result <= 64'd31));

    assert_brev_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (in_strobe && opcode == OP_BITREV) |=>
            ($countones(out_result) == $countones($past(src_a))));

    assert_upper_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (in_strobe && opcode <= OP_BSWAP) |=> (out_result[2*WORD_W-1:WORD_W] == '0));
endmodule

bind lane_perm_unit lane_perm_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_strobe  (in_strobe),
    .opcode     (opcode),
    .src_a      (src_a),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/lane_perm_unit_test.sv
`timescale 1ns/100ps
module lane_perm_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_strobe;
    logic [3:0]  opcode;
    logic [31:0] src_a, src_b;
    logic [63:0] wide_a, wide_b;
    logic        out_valid;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    lane_perm_unit uut (
        .clk(clk), .rst(rst), .in_strobe(in_strobe), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .wide_a(wide_a), .wide_b(wide_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    localparam logic [63:0] WA = 64'h33333333_22222222;
    localparam logic [63:0] WB = 64'h11111111_AAAAAAAA;

    // {opcode, src_a, src_b, expected}
    localparam int NV = 24;
    localparam logic [131:0] VEC [NV] = '{
        {4'd0,  32'h76543210, 32'hFEDCBA98, 64'h00000000_543210FE},
        {4'd1,  32'h76543210, 32'hFEDCBA98, 64'h00000000_10FEDCBA},
        {4'd2,  32'h76543210, 32'hFEDCBA98, 64'h00000000_76FE54DC},
        {4'd3,  32'h76543210, 32'hFEDCBA98, 64'h00000000_32BA1098},
        {4'd4,  32'h76543210, 32'hFEDCBA98, 64'h00000000_76325410},
        {4'd5,  32'h76543210, 32'hFEDCBA98, 64'h00000000_54761032},
        {4'd4,  32'h76543210, 32'h00000000, 64'h00000000_76325410},
        {4'd5,  32'h76543210, 32'hFFFFFFFF, 64'h00000000_54761032},
        {4'd6,  32'h12345678, 32'h9ABCDEF0, 64'h22222222_11111111},
        {4'd7,  32'h12345678, 32'h9ABCDEF0, 64'h33333333_11111111},
        {4'd8,  32'h12345678, 32'h9ABCDEF0, 64'h22222222_AAAAAAAA},
        {4'd9,  32'h76543210, 32'h00000000, 64'h00000000_6E2A4C08},
        {4'd9,  32'h01800FF0, 32'hFFFFFFFF, 64'h00000000_8001F00F},
        {4'd10, 32'h00000000, 32'h00000000, 64'd31},
        {4'd10, 32'hFFFFFFFF, 32'h00000000, 64'd31},
        {4'd10, 32'h76543210, 32'h00000000, 64'd0},
        {4'd10, 32'h00010000, 32'h00000000, 64'd14},
        {4'd10, 32'hC0000000, 32'h00000000, 64'd1},
        {4'd10, 32'h80000000, 32'h00000000, 64'd0},
        {4'd0,  32'hAABBCCDD, 32'h11223344, 64'h00000000_BBCCDD11},
        {4'd1,  32'hAABBCCDD, 32'h11223344, 64'h00000000_DD112233},
        {4'd11, 32'hAABBCCDD, 32'h11223344, 64'd0},
        {4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'd0},
        {4'd10, 32'hFFFFFFFE, 32'h00000000, 64'd30}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R1/R11";
            4'd2, 4'd3: return "R2/R11";
            4'd4, 4'd5: return "R3/R11";
            4'd6:       return "R4";
            4'd7, 4'd8: return "R5";
            4'd9:       return "R6/R11";
            4'd10:      return "R7/R11";
            default:    return "R8";
        endcase
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: result actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: valid actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_strobe = 1'b0; opcode = 4'd0;
        src_a = '0; src_b = '0; wide_a = WA; wide_b = WB;
        repeat (3) @(negedge clk);
        // R10: reset state
        check1("R10", out_valid, 1'b0);
        check64("R10", out_result, 64'd0);
        rst = 1'b0;

        // vector walk, one strobe every other cycle
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {opcode, src_a, src_b} = VEC[i][131:64];
            in_strobe = 1'b1;
            @(negedge clk);
            in_strobe = 1'b0;
            check1("R9", out_valid, 1'b1);
            check64(req_of(VEC[i][131:128]), out_result, VEC[i][63:0]);
        end

        // R9: valid drops the cycle after, result holds while inputs change
        @(negedge clk);
        opcode = 4'd0; src_a = 32'hDEADBEEF; src_b = 32'hCAFEF00D;
        check1("R9", out_valid, 1'b0);
        check64("R9", out_result, 64'd30);
        repeat (2) @(negedge clk);
        check1("R9", out_valid, 1'b0);
        check64("R9", out_result, 64'd30);

        // back-to-back strobes: results in consecutive cycles
        opcode = 4'd6; in_strobe = 1'b1;
        @(negedge clk);
        opcode = 4'd5; src_a = 32'h76543210;
        check1("R9", out_valid, 1'b1);
        check64("R4", out_result, 64'h22222222_11111111);
        @(negedge clk);
        in_strobe = 1'b0;
        check1("R9", out_valid, 1'b1);
        check64("R3", out_result, 64'h00000000_54761032);
        @(negedge clk);
        check1("R9", out_valid, 1'b0);

        // R10: reset in the same cycle as a strobe
        opcode = 4'd7; in_strobe = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_strobe = 1'b0; rst = 1'b0;
        check1("R10", out_valid, 1'b0);
        check64("R10", out_result, 64'd0);

        @(negedge clk);
        finish_run();
    end
endmodule